// File: doc/BRIEF.md
# RTC Alarm and Periodic Tick Interrupt Unit

This unit raises the interrupt and wake-up requests of a real-time clock. It watches the running BCD time and date words coming from the calendar counters and compares them with a programmed alarm time and date. It also divides a 128 Hz timebase into a periodic tick whose rate is chosen with a 3-bit selector.

Both events set sticky flags. Software clears a flag by writing 1 to its bit. Each flag has an enable bit. The interrupt request is high while any flag and its enable are both 1. When a hardware event sets a flag whose enable is already 1, the unit also sends a one-cycle wake-up pulse to the power controller.

The calendar counters live outside this block. They present the time and date words together with a one-cycle strobe on every seconds update. Registers are reached through a simple word-indexed write port. Reads are combinational on the address.

Top module: `rtc_irq`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `wake_o` are 0.
- R2: The register map is indexed by `reg_addr_i`. Index 0 is the alarm time, where bits outside mask 0x3F7F7F read 0. Index 1 is the alarm date, where bits outside mask 0xFF1F3F read 0. Index 2 is the enables: bit 0 for the alarm, bit 1 for the tick. Index 3 is the flags: bit 0 for the alarm, bit 1 for the tick. Index 4 is the tick select in bits [2:0]. Indexes 5 to 7 and all unused bits read 0.
- R3: The tick flag (bit 1) is set at the clock edge that samples the n-th `base_tick_i` pulse since reset whenever n is a multiple of 2^(7-s), where s is the tick select value at that pulse. This gives a period of 1 s for s=0, 1/2 s for s=1, and so on down to 1/128 s for s=7.
- R4: Writing 1 to a flag bit at index 3 clears that flag. Writing 0 leaves it unchanged.
- R5: A hardware set and a software clear of the same flag in the same cycle leave the flag set.
- R6: `irq_o` is 1 exactly when (flags AND enables) is nonzero.
- R7: The alarm flag (bit 0) is set at an edge where `sec_upd_i` is 1 and both of these hold: `time_i` equals the alarm time under mask 0x3F7F7F, and `date_i` equals the alarm date under mask 0xFF1F3F. Equality while `sec_upd_i` is 0 sets nothing, and a difference in any BCD digit blocks the set.
- R8: `wake_o` is a one-cycle pulse after an edge at which a hardware event set a flag whose enable was 1. Writing an enable while a flag is pending gives no wake pulse.
- R9: Flags are set whatever the enables are, so enabling a pending flag later raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_tick_i | input | 1 | One-cycle 128 Hz timebase enable |
| sec_upd_i | input | 1 | One-cycle strobe on each seconds update |
| time_i | input | 24 | Running BCD time word |
| date_i | input | 24 | Running BCD date word |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up pulse |

## Verification
The tick path is swept over all eight select values with 256 timebase pulses each, for 2048 pulses in all. The expected flag is computed from the global pulse count modulo the selected period, which shows that phase is kept when the rate changes. The alarm path is first driven with a full match while the update strobe is low. It is then driven with six single-digit mismatches in the time word and six in the date word, and finally with a difference in an unmasked bit only. This separates gating, per-digit comparison and masking. Enable combinations, a write-0, and a clear that collides with a set show the flag and interrupt rules apart from each other.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int WORD_W  = 24;
  localparam int NUM_SRC = 2;
  localparam int SRC_ALARM = 0;
  localparam int SRC_TICK  = 1;

  localparam logic [WORD_W-1:0] TIME_MASK = 24'h3F7F7F;
  localparam logic [WORD_W-1:0] DATE_MASK = 24'hFF1F3F;

  localparam int IDX_ALM_TIME = 0;
  localparam int IDX_ALM_DATE = 1;
  localparam int IDX_ENABLE   = 2;
  localparam int IDX_FLAGS    = 3;
  localparam int IDX_TICK_SEL = 4;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_irq_pkg::*;
(
  input  logic              upd_i,
  input  logic [WORD_W-1:0] time_i,
  input  logic [WORD_W-1:0] date_i,
  input  logic [WORD_W-1:0] alm_time_i,
  input  logic [WORD_W-1:0] alm_date_i,
  output logic              hit_o
);
  logic time_eq, date_eq;

  always_comb begin
    time_eq = ((time_i ^ alm_time_i) & TIME_MASK) == '0;
    date_eq = ((date_i ^ alm_date_i) & DATE_MASK) == '0;
    // evaluated only on the seconds strobe: one set per match second
    hit_o   = upd_i && time_eq && date_eq;
  end
endmodule

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int TB_LOG2 = 7,
  parameter int SEL_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [TB_LOG2-1:0] cnt_q, mask;
  int unsigned        span;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (base_i) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    span = (int'(sel_i) >= TB_LOG2) ? 0 : TB_LOG2 - int'(sel_i);
    mask = ~({TB_LOG2{1'b1}} << span);
  end

  assign tick_o = base_i && ((cnt_q & mask) == mask);

  a_r3_no_tick_without_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !base_i |-> !tick_o);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic [N-1:0] flag_q;
  logic         wake_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end

    a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
    a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
    a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= |(set_i & en_i);
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);
  assign wake_o = wake_q;
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
  import rtc_irq_pkg::*;
#(
  parameter int TB_LOG2 = 7,
  parameter int SEL_W   = 3,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_tick_i,
  input  logic              sec_upd_i,
  input  logic [WORD_W-1:0] time_i,
  input  logic [WORD_W-1:0] date_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [WORD_W-1:0]  alm_time_q, alm_date_q;
  logic [NUM_SRC-1:0] en_q, set, clr, flags;
  logic [SEL_W-1:0]   sel_q;
  logic               alarm_hit, tick_hit;
  logic               wr_time, wr_date, wr_en, wr_flags, wr_sel;

  always_comb begin
    wr_time  = reg_we_i && (reg_addr_i == ADDR_W'(IDX_ALM_TIME));
    wr_date  = reg_we_i && (reg_addr_i == ADDR_W'(IDX_ALM_DATE));
    wr_en    = reg_we_i && (reg_addr_i == ADDR_W'(IDX_ENABLE));
    wr_flags = reg_we_i && (reg_addr_i == ADDR_W'(IDX_FLAGS));
    wr_sel   = reg_we_i && (reg_addr_i == ADDR_W'(IDX_TICK_SEL));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_time_q <= '0;
      alm_date_q <= '0;
      en_q       <= '0;
      sel_q      <= '0;
    end else begin
      if (wr_time) alm_time_q <= reg_wdata_i[WORD_W-1:0] & TIME_MASK;
      if (wr_date) alm_date_q <= reg_wdata_i[WORD_W-1:0] & DATE_MASK;
      if (wr_en)   en_q       <= reg_wdata_i[NUM_SRC-1:0];
      if (wr_sel)  sel_q      <= reg_wdata_i[SEL_W-1:0];
    end
  end

  rtc_alarm_cmp u_alarm (
    .upd_i      (sec_upd_i),
    .time_i     (time_i),
    .date_i     (date_i),
    .alm_time_i (alm_time_q),
    .alm_date_i (alm_date_q),
    .hit_o      (alarm_hit)
  );

  rtc_tick_div #(.TB_LOG2(TB_LOG2), .SEL_W(SEL_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .base_i (base_tick_i),
    .sel_i  (sel_q),
    .tick_o (tick_hit)
  );

  always_comb begin
    set            = '0;
    set[SRC_ALARM] = alarm_hit;
    set[SRC_TICK]  = tick_hit;
    clr            = wr_flags ? reg_wdata_i[NUM_SRC-1:0] : '0;
  end

  rtc_irq_flags #(.N(NUM_SRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (clr),
    .en_i   (en_q),
    .flag_o (flags),
    .irq_o  (irq_o),
    .wake_o (wake_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (int'(reg_addr_i))
      IDX_ALM_TIME: reg_rdata_o = DATA_W'(alm_time_q);
      IDX_ALM_DATE: reg_rdata_o = DATA_W'(alm_date_q);
      IDX_ENABLE:   reg_rdata_o = DATA_W'(en_q);
      IDX_FLAGS:    reg_rdata_o = DATA_W'(flags);
      IDX_TICK_SEL: reg_rdata_o = DATA_W'(sel_q);
      default:      reg_rdata_o = '0;
    endcase
  end

  a_r6_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags != '0));
  a_r7_no_alarm_off_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_upd_i && !flags[SRC_ALARM]) |=> !flags[SRC_ALARM]);
endmodule

// File: tb/rtc_irq_test.sv
`timescale 1ns/1ps
module rtc_irq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_tick_i = 1'b0;
  logic        sec_upd_i = 1'b0;
  logic [23:0] time_i = '0;
  logic [23:0] date_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, wake_o;

  int tests = 0, fails = 0, npulse = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rtc_irq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_tick_i(base_tick_i), .sec_upd_i(sec_upd_i),
    .time_i(time_i), .date_i(date_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr_i = 3'(a);
    #1 d = reg_rdata_o;
  endtask

  task automatic base_pulse();
    @(negedge clk_i);
    base_tick_i = 1'b1;
    @(negedge clk_i);
    base_tick_i = 1'b0;
    npulse++;
  endtask

  task automatic upd_pulse(logic [23:0] t, logic [23:0] d);
    @(negedge clk_i);
    time_i = t; date_i = d; sec_upd_i = 1'b1;
    @(negedge clk_i);
    sec_upd_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [23:0] at, ad;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(a, d); chk("R1 reg", d, 0); end
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 wake", 32'(wake_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2 map and masks
    for (int a = 0; a < 8; a++) wr(a, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 time mask", d, 32'h003F7F7F);
    rd(1, d); chk("R2 date mask", d, 32'h00FF1F3F);
    rd(2, d); chk("R2 enable", d, 32'h3);
    rd(3, d); chk("R2 flags after w1c", d, 32'h0);
    rd(4, d); chk("R2 tick sel", d, 32'h7);
    for (int a = 5; a < 8; a++) begin rd(a, d); chk("R2 unused", d, 0); end

    // R3 tick sweep with R8 wake, tick enabled only
    wr(2, 32'h2);
    for (int s = 0; s < 8; s++) begin
      wr(4, 32'(s));
      for (int k = 0; k < 256; k++) begin
        bit exp_t;
        base_pulse();
        exp_t = (npulse % (1 << (7 - s))) == 0;
        rd(3, d);
        chk($sformatf("R3 tick sel=%0d n=%0d", s, npulse), d, {30'd0, exp_t, 1'b0});
        chk("R8 tick wake", 32'(wake_o), 32'(exp_t));
        chk("R6 tick irq", 32'(irq_o), 32'(exp_t));
        if (exp_t) wr(3, 32'h2);
      end
    end

    // R7 alarm
    at = 24'h235959; ad = 24'h991231;
    wr(0, 32'(at)); wr(1, 32'(ad)); wr(2, 32'h0);
    @(negedge clk_i); time_i = at; date_i = ad;
    repeat (3) @(negedge clk_i);
    rd(3, d); chk("R7 no strobe no set", d, 0);
    for (int f = 0; f < 6; f++) begin
      upd_pulse(at ^ 24'(1 << (f*4)), ad); rd(3, d); chk("R7 time digit mismatch", d, 0);
      upd_pulse(at, ad ^ 24'(1 << (f*4))); rd(3, d); chk("R7 date digit mismatch", d, 0);
    end
    upd_pulse(at | 24'h000080, ad | 24'h00C040); rd(3, d);
    chk("R7 unmasked bits ignored", d, 1);
    chk("R8 no wake when disabled", 32'(wake_o), 0);
    // R9 / R6 enable combinations
    chk("R9 flag while disabled irq", 32'(irq_o), 0);
    wr(2, 32'h2); chk("R6 other enable", 32'(irq_o), 0);
    wr(2, 32'h1); chk("R6 alarm enabled", 32'(irq_o), 1);
    chk("R8 enable write no wake", 32'(wake_o), 0);
    // R4 write 0 then 1
    wr(3, 32'h0); rd(3, d); chk("R4 write0 keeps", d, 1);
    wr(3, 32'h1); rd(3, d); chk("R4 write1 clears", d, 0);
    chk("R6 irq drops", 32'(irq_o), 0);
    // R8 enabled alarm wake
    upd_pulse(at, ad);
    chk("R8 alarm wake", 32'(wake_o), 1);
    @(negedge clk_i); chk("R8 wake one cycle", 32'(wake_o), 0);
    wr(3, 32'h1);
    // R5 set and clear collide
    @(negedge clk_i);
    time_i = at; date_i = ad; sec_upd_i = 1'b1;
    reg_we_i = 1'b1; reg_addr_i = 3'd3; reg_wdata_i = 32'h1;
    @(negedge clk_i);
    sec_upd_i = 1'b0; reg_we_i = 1'b0; reg_wdata_i = '0;
    rd(3, d); chk("R5 set beats clear", d, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule